// File: doc/BRIEF.md
# Disk Controller Transfer Request Gating

This block produces the transfer request, the interrupt line and the density-select level of a floppy-style disk controller while a command is in its execution phase. The datapath sends a strobe for each byte that is ready to move. The block counts these bytes and raises a DMA request while any are waiting, provided that DMA is permitted. DMA is permitted when the Specify command chose DMA mode and the interface-mode gate is open. Each acknowledged byte is consumed, and a one-cycle memory strobe reports the direction of the transfer.

The interface mode decides two things: whether the DMA-enable bit of the digital output register gates DMA and the interrupt, and the polarity of the density-select output. The request handshake is either single-byte or burst, chosen by a configuration bit. A terminal count that arrives with an acknowledge ends the transfer. It drops the request, empties the byte count and sends a completion pulse to the phase sequencer.

Top module: `dma_req_gate`

## Requirements
- R1: After reset, drq, irqOut, denselOut, memRdStb, memWrStb and xferDone are all 0.
- R2: In mode 00 (AT), mode 10 (Model 30) and mode 11 (treated as AT), drq is held low and irqOut stays 0 when dorDmaEn is 0. Both signals take effect one cycle after the inputs are sampled.
- R3: In mode 01 (PS/2), dorDmaEn has no effect: a registered intEvent appears on irqOut one cycle later, and DMA requests are raised.
- R4: denselOut equals densHigh one cycle later in modes 00 and 11, and equals the inverse of densHigh one cycle later in modes 01 and 10.
- R5: drq is never raised while specDmaMode is 0 (programmed I/O).
- R6: With burstEn at 0, drq is low in the cycle after each acknowledge. It rises again on the next cycle if bytes are still pending.
- R7: With burstEn at 1, drq stays high across an acknowledge while at least one byte remains pending after it.
- R8: Each dataReady strobe adds one pending byte, up to DEPTH (default 16); strobes beyond that are dropped. drq rises one cycle after the count becomes nonzero. An acknowledge that arrives while drq is low is ignored.
- R9: One cycle after an acknowledge, xferType 00 (disk to memory) pulses memWrStb, xferType 01 (memory to disk) pulses memRdStb, and xferType 10 (verify) or 11 pulses neither strobe.
- R10: termCount together with an acknowledge of a raised drq does three things: drq is 0 on the next cycle, xferDone pulses for exactly that cycle, and the pending count is cleared (a dataReady in the same cycle is dropped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ifMode | input | 2 | Interface mode: 00 AT, 01 PS/2, 10 Model 30, 11 AT |
| dorDmaEn | input | 1 | DMA-enable bit of the digital output register |
| specDmaMode | input | 1 | DMA mode selected by the Specify command |
| burstEn | input | 1 | Burst handshake enable |
| xferType | input | 2 | 00 disk to memory, 01 memory to disk, 10 verify, 11 none |
| dataReady | input | 1 | One byte ready to move |
| dmaAck | input | 1 | DMA acknowledge |
| termCount | input | 1 | Terminal count, valid with dmaAck |
| intEvent | input | 1 | Interrupt event from the controller |
| densHigh | input | 1 | Logical high-density select |
| drq | output | 1 | DMA request |
| irqOut | output | 1 | Gated interrupt |
| denselOut | output | 1 | Density select at the mode's polarity |
| memRdStb | output | 1 | Memory read strobe for one acknowledged byte |
| memWrStb | output | 1 | Memory write strobe for one acknowledged byte |
| xferDone | output | 1 | Completion pulse on terminal count |

## Verification
The bench attacks the single-byte gap. A design that keeps drq high after an acknowledge in single mode would move two bytes per request. It also drives the burst tail: a design that drops drq early in burst mode, or holds it past the last pending byte, would stall or over-run the byte source. PS/2 mode is run with the DMA-enable bit cleared, because a design that wrongly gates it would silence both DMA and the interrupt. Further cases cover count saturation, acknowledges that arrive while drq is low, a terminal count that lands on the same edge as a new byte, and verify cycles, where a wrong design would fire a memory strobe.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;
  typedef enum logic [1:0] {
    MODE_AT    = 2'b00,
    MODE_PS2   = 2'b01,
    MODE_M30   = 2'b10,
    MODE_ATALT = 2'b11
  } ifMode_e;

  typedef enum logic [1:0] {
    XF_TO_MEM   = 2'b00,
    XF_FROM_MEM = 2'b01,
    XF_VERIFY   = 2'b10,
    XF_NONE     = 2'b11
  } xfer_e;

  typedef struct packed {
    logic consume;
    logic clearAll;
    logic irqGate;
    logic densInvert;
  } ctrlStrb_t;
endpackage

// File: rtl/dma_gate_dp.sv
module dma_gate_dp
  import dma_gate_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  input  logic      dataReady,
  input  logic [1:0] xferType,
  input  logic      intEvent,
  input  logic      densHigh,
  output logic      curNonZero,
  output logic      nxtNonZero,
  output logic      irqOut,
  output logic      denselOut,
  output logic      memRdStb,
  output logic      memWrStb
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] pendCnt;
  logic [CW-1:0] pendNxt;
  xfer_e         xfKind;

  assign xfKind = xfer_e'(xferType);

  // R8 pending byte count with saturation, R10 clear on terminal count
  always_comb begin
    pendNxt = pendCnt;
    if (strb.clearAll) begin
      pendNxt = '0;
    end else if (dataReady && !strb.consume) begin
      if (pendCnt != CAP) pendNxt = pendCnt + 1'b1;
    end else if (!dataReady && strb.consume) begin
      pendNxt = pendCnt - 1'b1;
    end
  end

  assign curNonZero = (pendCnt != '0);
  assign nxtNonZero = (pendNxt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt   <= '0;
      irqOut    <= 1'b0;
      denselOut <= 1'b0;
      memRdStb  <= 1'b0;
      memWrStb  <= 1'b0;
    end else begin
      pendCnt   <= pendNxt;
      irqOut    <= intEvent && strb.irqGate;
      denselOut <= densHigh ^ strb.densInvert;
      memWrStb  <= strb.consume && (xfKind == XF_TO_MEM);
      memRdStb  <= strb.consume && (xfKind == XF_FROM_MEM);
    end
  end

  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= CAP);

  a_r9_verify_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strb.consume && xfKind == XF_VERIFY) |=> (!memRdStb && !memWrStb));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdStb && memWrStb));
endmodule

// File: rtl/dma_gate_ctrl.sv
module dma_gate_ctrl
  import dma_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] ifMode,
  input  logic      dorDmaEn,
  input  logic      specDmaMode,
  input  logic      burstEn,
  input  logic      dmaAck,
  input  logic      termCount,
  input  logic      curNonZero,
  input  logic      nxtNonZero,
  output ctrlStrb_t strb,
  output logic      drqOut,
  output logic      doneOut
);
  ifMode_e modeKind;
  logic    dmaGate;
  logic    reqOk;
  logic    ackHit;
  logic    tcHit;
  logic    drqNxt;

  assign modeKind = ifMode_e'(ifMode);
  // R2 / R3: PS/2 ignores the output-register enable
  assign dmaGate  = (modeKind == MODE_PS2) || dorDmaEn;
  assign reqOk    = dmaGate && specDmaMode;
  assign ackHit   = dmaAck && drqOut;
  assign tcHit    = ackHit && termCount;

  always_comb begin
    strb.consume    = ackHit;
    strb.clearAll   = tcHit;
    strb.irqGate    = dmaGate;
    strb.densInvert = (modeKind == MODE_PS2) || (modeKind == MODE_M30);
  end

  // R6 single gap, R7 burst hold
  always_comb begin
    if (!reqOk || tcHit)  drqNxt = 1'b0;
    else if (ackHit)      drqNxt = burstEn && nxtNonZero;
    else                  drqNxt = curNonZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drqOut  <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      drqOut  <= drqNxt;
      doneOut <= tcHit;
    end
  end

  a_r5_no_drq_pio: assert property (@(posedge clk) disable iff (!rstN)
    !specDmaMode |=> !drqOut);

  a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
    (!dorDmaEn && modeKind != MODE_PS2) |=> !drqOut);

  a_r6_single_gap: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && drqOut && !burstEn) |=> !drqOut);

  a_r10_tc_end: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && drqOut && termCount) |=> (!drqOut && doneOut));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_gate_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] ifMode,
  input  logic       dorDmaEn,
  input  logic       specDmaMode,
  input  logic       burstEn,
  input  logic [1:0] xferType,
  input  logic       dataReady,
  input  logic       dmaAck,
  input  logic       termCount,
  input  logic       intEvent,
  input  logic       densHigh,
  output logic       drq,
  output logic       irqOut,
  output logic       denselOut,
  output logic       memRdStb,
  output logic       memWrStb,
  output logic       xferDone
);
  ctrlStrb_t strb;
  logic      curNonZero;
  logic      nxtNonZero;

  dma_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ifMode(ifMode), .dorDmaEn(dorDmaEn),
    .specDmaMode(specDmaMode), .burstEn(burstEn), .dmaAck(dmaAck),
    .termCount(termCount), .curNonZero(curNonZero), .nxtNonZero(nxtNonZero),
    .strb(strb), .drqOut(drq), .doneOut(xferDone)
  );

  dma_gate_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataReady(dataReady),
    .xferType(xferType), .intEvent(intEvent), .densHigh(densHigh),
    .curNonZero(curNonZero), .nxtNonZero(nxtNonZero), .irqOut(irqOut),
    .denselOut(denselOut), .memRdStb(memRdStb), .memWrStb(memWrStb)
  );
endmodule

// File: tb/dma_req_gate_tb.sv
module dma_req_gate_tb;
  localparam int DEPTH = 16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] ifMode = 2'b00;
  logic dorDmaEn = 1'b0, specDmaMode = 1'b0, burstEn = 1'b0;
  logic [1:0] xferType = 2'b00;
  logic dataReady = 1'b0, dmaAck = 1'b0, termCount = 1'b0;
  logic intEvent = 1'b0, densHigh = 1'b0;
  logic drq, irqOut, denselOut, memRdStb, memWrStb, xferDone;

  int errors = 0;
  int checks = 0;
  string scen = "R1";
  bit autoAck = 1'b0;
  bit running = 1'b0;

  // behavioural reference state
  int  mPend = 0;
  bit  mDrq = 0, mIrq = 0, mDen = 0, mRd = 0, mWr = 0, mDone = 0;

  always #4 clk = ~clk;

  dma_req_gate #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .ifMode(ifMode), .dorDmaEn(dorDmaEn),
    .specDmaMode(specDmaMode), .burstEn(burstEn), .xferType(xferType),
    .dataReady(dataReady), .dmaAck(dmaAck), .termCount(termCount),
    .intEvent(intEvent), .densHigh(densHigh), .drq(drq), .irqOut(irqOut),
    .denselOut(denselOut), .memRdStb(memRdStb), .memWrStb(memWrStb),
    .xferDone(xferDone)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend <= 0; mDrq <= 0; mIrq <= 0; mDen <= 0; mRd <= 0; mWr <= 0; mDone <= 0;
    end else begin
      bit gateOpen, permit, took, tcNow, nd;
      int np;
      gateOpen = (ifMode == 2'b01) || dorDmaEn;
      permit   = gateOpen && specDmaMode;
      took     = dmaAck && mDrq;
      tcNow    = took && termCount;
      np = mPend;
      if (tcNow) np = 0;
      else if (dataReady && !took) begin if (mPend < DEPTH) np = mPend + 1; end
      else if (!dataReady && took) np = mPend - 1;
      if (!permit || tcNow) nd = 0;
      else if (took) nd = burstEn && (np > 0);
      else nd = (mPend > 0);
      mPend <= np;
      mDrq  <= nd;
      mDone <= tcNow;
      mWr   <= took && (xferType == 2'b00);
      mRd   <= took && (xferType == 2'b01);
      mIrq  <= intEvent && gateOpen;
      mDen  <= (ifMode == 2'b01 || ifMode == 2'b10) ? !densHigh : densHigh;
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", scen, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("drq", drq, mDrq);
      chk("irqOut", irqOut, mIrq);
      chk("denselOut", denselOut, mDen);
      chk("memRdStb", memRdStb, mRd);
      chk("memWrStb", memWrStb, mWr);
      chk("xferDone", xferDone, mDone);
    end
  end

  // advance one cycle; inputs change 2 ns after the edge
  task automatic step();
    @(posedge clk); #2;
    dataReady = 1'b0; intEvent = 1'b0; termCount = 1'b0;
    dmaAck = autoAck && mDrq;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      dataReady = 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    scen = "R1";
    chk("R1 reset drq", drq, 1'b0);
    chk("R1 reset irqOut", irqOut, 1'b0);
    chk("R1 reset denselOut", denselOut, 1'b0);
    chk("R1 reset strobes", memRdStb | memWrStb | xferDone, 1'b0);
    rstN = 1'b1;
    running = 1'b1;

    // R6 single mode disk to memory in AT mode
    scen = "R6"; ifMode = 2'b00; dorDmaEn = 1; specDmaMode = 1; burstEn = 0;
    xferType = 2'b00; autoAck = 1;
    feed(4); idle(16);

    // R7 burst memory to disk
    scen = "R7"; burstEn = 1; xferType = 2'b01;
    feed(6); idle(12);
    feed(1); step(); dataReady = 1; step(); dataReady = 1; idle(10);

    // R9 verify and type 11: no strobes
    scen = "R9"; xferType = 2'b10; feed(3); idle(8);
    xferType = 2'b11; feed(2); idle(8);
    xferType = 2'b00; burstEn = 0;

    // R2 gate closed in AT and Model 30
    scen = "R2"; dorDmaEn = 0; autoAck = 0;
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      ifMode = 2'(m);
      step(); intEvent = 1; feed(2); idle(4);
    end
    // drain the bytes left pending once the gate opens again
    dorDmaEn = 1; autoAck = 1; idle(12);

    // R3 PS/2 ignores the enable bit
    scen = "R3"; ifMode = 2'b01; dorDmaEn = 0;
    step(); intEvent = 1; feed(3); idle(10);

    // R4 density polarity in every mode
    scen = "R4";
    for (int m = 0; m < 4; m++) begin
      ifMode = 2'(m); step(); densHigh = 1; idle(3); densHigh = 0; idle(3);
    end

    // R5 programmed I/O
    scen = "R5"; ifMode = 2'b00; dorDmaEn = 1; specDmaMode = 0;
    feed(3); idle(4);
    specDmaMode = 1; idle(10);

    // R8 saturation and ignored acknowledge
    scen = "R8"; specDmaMode = 0; autoAck = 0; feed(DEPTH + 5);
    step(); dmaAck = 1; step(); dmaAck = 1; idle(2);
    specDmaMode = 1; burstEn = 1; autoAck = 1; idle(DEPTH + 8);

    // R10 terminal count mid burst, with a byte arriving on the same edge
    scen = "R10"; autoAck = 0; feed(5); idle(3);
    step(); dmaAck = mDrq; idle(1);
    dmaAck = mDrq; termCount = 1; dataReady = 1;
    idle(6);
    autoAck = 1; feed(2); idle(2);
    step(); dmaAck = mDrq; termCount = mDrq; idle(6);

    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule